// File: doc/BRIEF.md
# Dual-Mode H-Bridge Gate Controller

This block is the digital control for one motor driver built from two H-bridges. A static mode input chooses how the pair is used. In step mode each bridge drives one winding of a bipolar stepper. Each bridge has its own direction bit and a two-bit current code. The code selects a comparator threshold. A fixed off-time chopper then acts on that bridge's comparator trip input. In DC mode both bridges receive identical gate commands, so they act in parallel. They are driven from an external PWM pin and a DC direction bit.

Every leg has a high-side and a low-side gate enable. Both pass through a break-before-make stage, so the two switches of one leg are never on together. The stage also holds a programmable dead gap on each change of side. Inputs for overtemperature, overtemperature recovery and DC overcurrent protect the drive. A drive enable and an asynchronous reset force all gates off. The analog sensing, the comparators and the power devices sit outside the block. All timing is counted in system-clock cycles and set by parameters.

Top module: `dual_bridge_ctl`

## Requirements
- R1: With step_mode = 0 (DC mode), both bridges always receive the same gate pattern: hs_a[0]=hs_a[1], ls_a[0]=ls_a[1], hs_b[0]=hs_b[1], ls_b[0]=ls_b[1]. With step_mode = 1, each bridge follows its own ph_dir, ph_code and cmp_trip bits.
- R2: In DC mode with the drive enabled and no fault, pwm_in = 0 turns on both high sides and turns off both low sides, whatever dc_dir is. With pwm_in = 1 and dc_dir = 0, leg A is pulled low and leg B high. With pwm_in = 1 and dc_dir = 1, leg A is high and leg B low.
- R3: In step mode, bridge i takes its current code from ph_code[2i+1:2i] = {I1,I0}. It reports the comparator threshold on lvl_sel[2i+1:2i]. Code 00 gives 3 (full current), code 01 gives 2 (medium), code 10 gives 1 (low), and zero current gives 0. lvl_sel is 0 in DC mode, while disabled and during overtemperature.
- R4: A step code of 11 turns all four gates of that bridge off (fast decay) and reports lvl_sel 0. The bridge's direction bit then has no effect.
- R5: In step mode, ph_dir[i] = 1 drives current from A to B (hs_a and ls_b on). ph_dir[i] = 0 drives it from B to A (hs_b and ls_a on).
- R6: After each turn-on in step mode, cmp_trip is ignored for BLANK_CYC cycles. A trip seen after that switches the bridge fully off for TOFF_CYC cycles. The bridge then turns on again and a new blanking period starts.
- R7: A leg never has its high-side and low-side enables high in the same cycle. When a leg changes side, both enables stay low for DEAD_CYC+1 cycles before the new side turns on.
- R8: In DC mode, a dc_ovc pulse turns every gate off for OC_CYC cycles. After that the normal DC pattern resumes.
- R9: A pulse on ot_hot latches an overtemperature state. In step mode this turns all gates off. In DC mode it drives all high sides on and all low sides off. The state persists until ot_cool is seen while ot_hot is low.
- R10: With drv_en = 0, all gates are off one clock edge later. With rst_n = 0, all gates are off at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drv_en | input | 1 | Drive enable; 0 forces all gates off |
| step_mode | input | 1 | 1 = stepper mode, 0 = paralleled DC mode |
| pwm_in | input | 1 | DC-mode PWM input |
| dc_dir | input | 1 | DC-mode direction bit |
| ph_dir | input | 2 | Step-mode direction bit per bridge |
| ph_code | input | 4 | Step-mode current code per bridge, {I1,I0} at [2i+1:2i] |
| cmp_trip | input | 2 | Current comparator trip per bridge |
| dc_ovc | input | 1 | DC overcurrent indication |
| ot_hot | input | 1 | Overtemperature flag |
| ot_cool | input | 1 | Temperature-recovered flag |
| hs_a | output | 2 | High-side enable, leg A, per bridge |
| ls_a | output | 2 | Low-side enable, leg A, per bridge |
| hs_b | output | 2 | High-side enable, leg B, per bridge |
| ls_b | output | 2 | Low-side enable, leg B, per bridge |
| lvl_sel | output | 4 | Comparator threshold select per bridge |

## Verification
The latency through the block follows from its registers.
- Turning a gate off, or turning one on after a long idle, shows after one edge. This is the registered leg stage. The path to lvl_sel adds no register.
- A change of side goes dark on the first edge and turns the new side on at edge DEAD_CYC+2.
- A fault pulse adds one edge for its latch, so gates fall on the second edge.
- In the chopper, a trip held from turn-on removes the gates at edge BLANK_CYC+2. They return at edge BLANK_CYC+TOFF_CYC+2.

The bench samples 2 ns after an edge. It counts edges from the moment it drives a stimulus. It checks exactly at these edges, or a few cycles inside each window. A monitor watches every cycle for both enables of one leg being high at once.

// File: rtl/bdrv_pkg.sv
package bdrv_pkg;

   typedef enum logic [1:0] {
      LEG_OFF = 2'b00,
      LEG_HI  = 2'b01,
      LEG_LO  = 2'b10
   } leg_cmd_t;

   typedef enum logic [1:0] {
      CH_BLANK = 2'b00,
      CH_SENSE = 2'b01,
      CH_DECAY = 2'b10
   } chop_st_t;

   // current code {I1,I0} -> threshold select (3 full, 2 medium, 1 low, 0 none)
   function automatic logic [1:0] lvl_of(input logic [1:0] code);
      case (code)
         2'b00:   lvl_of = 2'd3;
         2'b01:   lvl_of = 2'd2;
         2'b10:   lvl_of = 2'd1;
         default: lvl_of = 2'd0;
      endcase
   endfunction

endpackage

// File: rtl/bdrv_leg_dt.sv
// Break-before-make stage for one half-bridge leg.
module bdrv_leg_dt
   import bdrv_pkg::*;
#(
   parameter int DEAD_CYC = 10
) (
   input  logic     clk,
   input  logic     rst_n,
   input  leg_cmd_t req,
   output logic     hs,
   output logic     ls
);
   localparam int W = $clog2(DEAD_CYC + 1);
   localparam logic [W-1:0] DEAD_V = W'(DEAD_CYC);

   leg_cmd_t      cur;
   logic [W-1:0]  gap_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur     <= LEG_OFF;
         gap_cnt <= DEAD_V;
      end else if (req == cur) begin
         if (cur == LEG_OFF && gap_cnt < DEAD_V)
            gap_cnt <= gap_cnt + 1'b1;
      end else if (cur != LEG_OFF) begin
         cur     <= LEG_OFF;
         gap_cnt <= '0;
      end else if (gap_cnt >= DEAD_V) begin
         cur <= req;
      end else begin
         gap_cnt <= gap_cnt + 1'b1;
      end
   end

   assign hs = (cur == LEG_HI);
   assign ls = (cur == LEG_LO);

endmodule

// File: rtl/bdrv_chopper.sv
// Fixed off-time chopper with leading-edge blanking for one winding.
module bdrv_chopper
   import bdrv_pkg::*;
#(
   parameter int BLANK_CYC = 25,
   parameter int TOFF_CYC  = 1450
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic dir,
   input  logic trip,
   output logic decay
);
   localparam int MAXC = (BLANK_CYC > TOFF_CYC) ? BLANK_CYC : TOFF_CYC;
   localparam int W    = $clog2(MAXC + 1);
   localparam logic [W-1:0] BLANK_LAST = W'(BLANK_CYC - 1);
   localparam logic [W-1:0] TOFF_LAST  = W'(TOFF_CYC - 1);

   chop_st_t     st;
   logic [W-1:0] cnt;
   logic         prev_dir;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= CH_BLANK;
         cnt      <= '0;
         prev_dir <= 1'b0;
      end else begin
         prev_dir <= dir;
         if (!active || dir != prev_dir) begin
            st  <= CH_BLANK;
            cnt <= '0;
         end else begin
            case (st)
               CH_BLANK: begin
                  if (cnt == BLANK_LAST) begin
                     st  <= CH_SENSE;
                     cnt <= '0;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               CH_SENSE: begin
                  if (trip) begin
                     st  <= CH_DECAY;
                     cnt <= '0;
                  end
               end
               default: begin
                  if (cnt == TOFF_LAST) begin
                     st  <= CH_BLANK;
                     cnt <= '0;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            endcase
         end
      end
   end

   assign decay = (st == CH_DECAY);

endmodule

// File: rtl/bdrv_protect.sv
// Overtemperature latch and DC overcurrent off-timer.
module bdrv_protect #(
   parameter int OC_CYC = 2000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dc_en,
   input  logic ovc,
   input  logic hot,
   input  logic cool,
   output logic ot_hold,
   output logic oc_block
);
   localparam int W = $clog2(OC_CYC + 1);
   localparam logic [W-1:0] OC_V = W'(OC_CYC);

   logic [W-1:0] oc_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ot_hold <= 1'b0;
      else if (hot)   ot_hold <= 1'b1;
      else if (cool)  ot_hold <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             oc_cnt <= '0;
      else if (!dc_en)        oc_cnt <= '0;
      else if (ovc)           oc_cnt <= OC_V;
      else if (oc_cnt != '0)  oc_cnt <= oc_cnt - 1'b1;
   end

   assign oc_block = (oc_cnt != '0);

endmodule

// File: rtl/dual_bridge_ctl.sv
module dual_bridge_ctl
   import bdrv_pkg::*;
#(
   parameter int N_BR      = 2,
   parameter int DEAD_CYC  = 10,
   parameter int BLANK_CYC = 25,
   parameter int TOFF_CYC  = 1450,
   parameter int OC_CYC    = 2000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              drv_en,
   input  logic              step_mode,
   input  logic              pwm_in,
   input  logic              dc_dir,
   input  logic [N_BR-1:0]   ph_dir,
   input  logic [2*N_BR-1:0] ph_code,
   input  logic [N_BR-1:0]   cmp_trip,
   input  logic              dc_ovc,
   input  logic              ot_hot,
   input  logic              ot_cool,
   output logic [N_BR-1:0]   hs_a,
   output logic [N_BR-1:0]   ls_a,
   output logic [N_BR-1:0]   hs_b,
   output logic [N_BR-1:0]   ls_b,
   output logic [2*N_BR-1:0] lvl_sel
);
   localparam int N_LEG = 2;

   if (N_BR < 1)          begin : g_bad_nbr   $error("N_BR must be at least 1");   end
   if (DEAD_CYC < 1)      begin : g_bad_dead  $error("DEAD_CYC must be at least 1"); end
   if (BLANK_CYC < 1)     begin : g_bad_blank $error("BLANK_CYC must be at least 1"); end
   if (TOFF_CYC < 1)      begin : g_bad_toff  $error("TOFF_CYC must be at least 1"); end
   if (OC_CYC <= DEAD_CYC) begin : g_bad_oc   $error("OC_CYC must exceed DEAD_CYC"); end

   logic ot_hold;
   logic oc_block;

   bdrv_protect #(.OC_CYC(OC_CYC)) prot_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .dc_en    (drv_en & ~step_mode),
      .ovc      (dc_ovc),
      .hot      (ot_hot),
      .cool     (ot_cool),
      .ot_hold  (ot_hold),
      .oc_block (oc_block)
   );

   for (genvar i = 0; i < N_BR; i++) begin : g_br
      logic [1:0] code;
      logic       zero_cur;
      logic       active;
      logic       decay;
      leg_cmd_t   req [N_LEG];
      logic [N_LEG-1:0] hs_l;
      logic [N_LEG-1:0] ls_l;

      assign code     = ph_code[2*i+1 -: 2];
      assign zero_cur = (code == 2'b11);
      assign active   = drv_en & step_mode & ~ot_hold & ~zero_cur;

      bdrv_chopper #(.BLANK_CYC(BLANK_CYC), .TOFF_CYC(TOFF_CYC)) chop_i (
         .clk   (clk),
         .rst_n (rst_n),
         .active(active),
         .dir   (ph_dir[i]),
         .trip  (cmp_trip[i]),
         .decay (decay)
      );

      always_comb begin
         req[0] = LEG_OFF;
         req[1] = LEG_OFF;
         if (drv_en) begin
            if (step_mode) begin
               if (active && !decay) begin
                  req[0] = ph_dir[i] ? LEG_HI : LEG_LO;
                  req[1] = ph_dir[i] ? LEG_LO : LEG_HI;
               end
            end else if (ot_hold) begin
               req[0] = LEG_HI;
               req[1] = LEG_HI;
            end else if (!oc_block) begin
               if (!pwm_in) begin
                  req[0] = LEG_HI;
                  req[1] = LEG_HI;
               end else begin
                  req[0] = dc_dir ? LEG_HI : LEG_LO;
                  req[1] = dc_dir ? LEG_LO : LEG_HI;
               end
            end
         end
      end

      for (genvar l = 0; l < N_LEG; l++) begin : g_leg
         bdrv_leg_dt #(.DEAD_CYC(DEAD_CYC)) leg_i (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (req[l]),
            .hs    (hs_l[l]),
            .ls    (ls_l[l])
         );
      end

      assign hs_a[i] = hs_l[0];
      assign ls_a[i] = ls_l[0];
      assign hs_b[i] = hs_l[1];
      assign ls_b[i] = ls_l[1];
      assign lvl_sel[2*i+1 -: 2] = active ? lvl_of(code) : 2'b00;
   end

endmodule

// File: rtl/bdrv_checker.sv
module bdrv_checker #(
   parameter int N_BR = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              drv_en,
   input logic              step_mode,
   input logic [2*N_BR-1:0] ph_code,
   input logic              ot_hot,
   input logic [N_BR-1:0]   hs_a,
   input logic [N_BR-1:0]   ls_a,
   input logic [N_BR-1:0]   hs_b,
   input logic [N_BR-1:0]   ls_b
);
   logic [4*N_BR-1:0] gates;
   assign gates = {hs_a, ls_a, hs_b, ls_b};

   assert_no_shoot_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((hs_a & ls_a) | (hs_b & ls_b)) == '0);

   assert_gap_hs_to_ls_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((ls_a & ~$past(ls_a) & $past(hs_a)) | (ls_b & ~$past(ls_b) & $past(hs_b))) == '0);

   assert_gap_ls_to_hs_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((hs_a & ~$past(hs_a) & $past(ls_a)) | (hs_b & ~$past(hs_b) & $past(ls_b))) == '0);

   assert_disable_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!drv_en) |-> gates == '0);

   assert_step_hot_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ot_hot, 2) && $past(step_mode && drv_en)) |-> gates == '0);

   for (genvar i = 0; i < N_BR; i++) begin : g_chk
      assert_zero_code_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
         $past(step_mode && drv_en && ph_code[2*i+1 -: 2] == 2'b11)
         |-> !hs_a[i] && !ls_a[i] && !hs_b[i] && !ls_b[i]);
   end

endmodule

bind dual_bridge_ctl bdrv_checker #(.N_BR(N_BR)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .drv_en    (drv_en),
   .step_mode (step_mode),
   .ph_code   (ph_code),
   .ot_hot    (ot_hot),
   .hs_a      (hs_a),
   .ls_a      (ls_a),
   .hs_b      (hs_b),
   .ls_b      (ls_b)
);

// File: tb/dual_bridge_ctl_tb_top.sv
`timescale 1ns/1ps
module dual_bridge_ctl_tb_top;
   localparam int DEAD  = 10;
   localparam int BLANK = 25;
   localparam int TOFF  = 1450;
   localparam int OCC   = 2000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       drv_en = 1'b0, step_mode = 1'b0, pwm_in = 1'b0, dc_dir = 1'b0;
   logic [1:0] ph_dir = 2'b00;
   logic [3:0] ph_code = 4'b1111;
   logic [1:0] cmp_trip = 2'b00;
   logic       dc_ovc = 1'b0, ot_hot = 1'b0, ot_cool = 1'b0;
   logic [1:0] hs_a, ls_a, hs_b, ls_b;
   logic [3:0] lvl_sel;

   int checks = 0;
   int errors = 0;
   int overlaps = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   dual_bridge_ctl #(.DEAD_CYC(DEAD), .BLANK_CYC(BLANK), .TOFF_CYC(TOFF), .OC_CYC(OCC)) dut_i (
      .clk(clk), .rst_n(rst_n), .drv_en(drv_en), .step_mode(step_mode), .pwm_in(pwm_in),
      .dc_dir(dc_dir), .ph_dir(ph_dir), .ph_code(ph_code), .cmp_trip(cmp_trip),
      .dc_ovc(dc_ovc), .ot_hot(ot_hot), .ot_cool(ot_cool),
      .hs_a(hs_a), .ls_a(ls_a), .hs_b(hs_b), .ls_b(ls_b), .lvl_sel(lvl_sel));

   wire [7:0] gates = {hs_a, ls_a, hs_b, ls_b};

   localparam logic [7:0] G_OFF  = 8'b00_00_00_00;
   localparam logic [7:0] G_HIHI = 8'b11_00_11_00;
   localparam logic [7:0] G_AB   = 8'b11_00_00_11;  // A high, B low
   localparam logic [7:0] G_BA   = 8'b00_11_11_00;  // A low, B high

   always @(negedge clk)
      if (rst_n && (((hs_a & ls_a) | (hs_b & ls_b)) != 2'b00)) overlaps++;

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic t_reset();
      chk("R10 reset gates", 32'(gates), 32'(G_OFF));
      chk("R10 reset lvl", 32'(lvl_sel), 0);
   endtask

   task automatic t_dc_table();
      step_mode = 0; drv_en = 1; pwm_in = 0; dc_dir = 0;
      edges(30);
      chk("R2 pwm0 dir0", 32'(gates), 32'(G_HIHI));
      chk("R1 lvl zero in DC", 32'(lvl_sel), 0);
      dc_dir = 1; edges(30);
      chk("R2 pwm0 dir1", 32'(gates), 32'(G_HIHI));
      pwm_in = 1; dc_dir = 0; edges(30);
      chk("R2 R1 pwm1 dir0", 32'(gates), 32'(G_BA));
      pwm_in = 1; dc_dir = 1; edges(30);
      chk("R2 R1 pwm1 dir1", 32'(gates), 32'(G_AB));
   endtask

   task automatic t_dead();
      dc_dir = 0; edges(30);
      dc_dir = 1;
      edges(1);
      chk("R7 first edge dark", 32'(gates), 32'(G_OFF));
      edges(DEAD);
      chk("R7 dark at DEAD+1", 32'(gates), 32'(G_OFF));
      edges(1);
      chk("R7 on at DEAD+2", 32'(gates), 32'(G_AB));
   endtask

   task automatic t_step_basic();
      step_mode = 1; ph_code = 4'b0000; ph_dir = 2'b11; edges(30);
      chk("R5 dir1 A to B", 32'(gates), 32'(G_AB));
      chk("R3 code00 full", 32'(lvl_sel), 32'h f);
      ph_dir = 2'b00; edges(30);
      chk("R5 dir0 B to A", 32'(gates), 32'(G_BA));
      ph_code = 4'b10_01; edges(5);
      chk("R3 code01 medium, code10 low", 32'(lvl_sel), 32'b01_10);
      ph_dir = 2'b10; edges(30);
      chk("R1 bridges independent", 32'(gates), 32'(8'b10_01_01_10));
      ph_code = 4'b11_00; edges(30);
      chk("R4 code11 bridge1 off", 32'(gates), 32'(8'b00_01_01_00));
      chk("R4 code11 lvl", 32'(lvl_sel), 32'b00_11);
      ph_code = 4'b1111; ph_dir = 2'b11; edges(30);
      chk("R4 code11 dir ignored", 32'(gates), 32'(G_OFF));
   endtask

   task automatic t_chop();
      ph_dir = 2'b11; ph_code = 4'b1111; edges(30);
      ph_code = 4'b0000; cmp_trip = 2'b01;
      edges(12);
      chk("R6 trip ignored in blanking", 32'(gates), 32'(G_AB));
      edges(BLANK + 4 - 12);
      chk("R6 trip turns bridge0 off", 32'(gates), 32'(8'b10_00_00_10));
      cmp_trip = 2'b00;
      edges(TOFF - 7);
      chk("R6 off-time still running", 32'(gates), 32'(8'b10_00_00_10));
      edges(7);
      chk("R6 restart after off-time", 32'(gates), 32'(G_AB));
   endtask

   task automatic t_ovc();
      step_mode = 0; pwm_in = 1; dc_dir = 1; edges(30);
      dc_ovc = 1; edges(1); dc_ovc = 0;
      edges(2);
      chk("R8 overcurrent off", 32'(gates), 32'(G_OFF));
      edges(OCC - 20);
      chk("R8 still off", 32'(gates), 32'(G_OFF));
      edges(25);
      chk("R8 retry", 32'(gates), 32'(G_AB));
   endtask

   task automatic t_ot();
      step_mode = 1; ph_code = 4'b0000; ph_dir = 2'b11; edges(30);
      ot_hot = 1; edges(1); ot_hot = 0;
      edges(2);
      chk("R9 step hot off", 32'(gates), 32'(G_OFF));
      chk("R9 step hot lvl", 32'(lvl_sel), 0);
      edges(200);
      chk("R9 latched", 32'(gates), 32'(G_OFF));
      ot_cool = 1; edges(1); ot_cool = 0;
      edges(3);
      chk("R9 resume after cool", 32'(gates), 32'(G_AB));
      step_mode = 0; pwm_in = 1; dc_dir = 1; edges(30);
      ot_hot = 1; edges(1); ot_hot = 0;
      edges(DEAD + 6);
      chk("R9 DC hot high sides", 32'(gates), 32'(G_HIHI));
      ot_cool = 1; edges(1); ot_cool = 0;
      edges(DEAD + 6);
      chk("R9 DC resume", 32'(gates), 32'(G_AB));
   endtask

   task automatic t_enable();
      pwm_in = 0; edges(30);
      chk("R2 all high before disable", 32'(gates), 32'(G_HIHI));
      drv_en = 0; edges(1);
      chk("R10 disable off", 32'(gates), 32'(G_OFF));
      drv_en = 1; edges(30);
      #3 rst_n = 0; #1;
      chk("R10 async reset off", 32'(gates), 32'(G_OFF));
      edges(2); rst_n = 1; edges(2);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         chk("R7 no leg overlap", 32'(overlaps), 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      edges(3);
      t_reset();
      rst_n = 1; edges(2);
      t_dc_table();
      t_dead();
      t_step_basic();
      t_chop();
      t_ovc();
      t_ot();
      t_enable();
      finish_run();
   end
endmodule